// File: doc/BRIEF.md
# Symmetric Pre-Add Decimating FIR Cell

This block is one filter cell with four multipliers, for 10-bit samples and 10-bit coefficients. Samples go into a tapped line. Each multiplier lane reads two samples from that line: one through a forward tap and one through a reverse tap. A pre-adder sums the two samples before the multiply. For a coefficient set that is symmetric, this gives eight taps from four products. An odd-length mode moves the reverse taps back by one position. The centre sample then meets itself in the pre-adder, so the caller supplies half the centre coefficient.

When a path enable is cleared, that operand becomes zero. With only one path enabled the pre-add is bypassed and the cell works as an asymmetric filter, which takes two clocks per output sample. A decimation code D-1 (D from 1 to 16) sets the spacing between taps. Over a window of D clocks the reverse taps step backward, one position per clock. The accumulator collects the partial sums of one window, each clock using a different coefficient set, which gives an 8·D-tap symmetric filter with one output every D clocks. A transfer strobe copies the finished accumulator into the result register. The coefficients are supplied from outside the block on every clock.

Top module: `pfir_cell`

## Requirements
- R1: A synchronous active-high `rst` clears `result`, the accumulator, every entry of the sample line and the window phase to zero.
- R2: When `shift_en` is 1 at a rising edge, `sample_in` enters line position 0 (the newest) and every held sample moves one position older. The sum formed in a cycle uses the line as it stands before that cycle's edge.
- R3: With D=1, `odd_len`=0 and both paths enabled, after samples x1..x8 (x8 newest) the cycle's sum is (x8+x1)c0+(x7+x2)c1+(x6+x3)c2+(x5+x4)c3. Here ck is lane k, which is `coef_in[10k+9:10k]`.
- R4: With D=1 and `odd_len`=1, after samples x1..x7 (x7 newest) the sum is (x7+x1)c0+(x6+x2)c1+(x5+x3)c2+(x4+x4)c3. The centre sample is doubled.
- R5: `fwd_en` alone uses only the forward sample of each lane, and `rev_en` alone uses only the reverse sample. With neither set, the sum is zero. At D=1 the reverse tap of lane j reads line position 7-j.
- R6: The tap spacing is D = `dec_code`+1. At window phase q, lane j reads forward position j·D and reverse position 6D+1-jD+2q, or 6D-jD+2q when `odd_len`=1. Suppose a D-clock window shifts on every clock, drives lane j with h[jD+D-1-q] and uses a symmetric h. It then yields Σ h[m]·x[n-m] over m < 8D, where n is the sample newest at the window's last clock.
- R7: `acc_en`=0 loads the cycle's sum into the accumulator and `acc_en`=1 adds to it. The phase is 0 on a load clock, rises by one on each accumulating clock, and returns to 0 after D-1.
- R8: `xfer` at an edge copies the accumulator value held before that edge into `result`. Without `xfer`, `result` keeps its value.
- R9: While `shift_en` is 0 the line does not change, whatever `sample_in` carries.
- R10: `data_signed`=1 reads samples as two's complement and 0 reads them as unsigned. `coef_signed` does the same for coefficients, independently of `data_signed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sample_in | input | 10 | Sample entering the line |
| coef_in | input | 40 | Four coefficient lanes, lane k in bits 10k+9:10k |
| dec_code | input | 4 | Decimation code, D = code + 1 |
| shift_en | input | 1 | Shift a sample into the line |
| fwd_en | input | 1 | Use the forward operand |
| rev_en | input | 1 | Use the reverse operand |
| odd_len | input | 1 | Odd-length symmetric tap alignment |
| acc_en | input | 1 | Add to the accumulator instead of loading it |
| xfer | input | 1 | Copy the accumulator to the result |
| data_signed | input | 1 | Samples are two's complement |
| coef_signed | input | 1 | Coefficients are two's complement |
| result | output | 28 | Filter output register, two's complement |

## Verification
The bench compares whole decimated windows at D=3 and at the deepest setting D=16 against a direct convolution over 8·D taps. A reverse tap that walks in the wrong direction across the phase, or that misses the far end of the line, gives wrong sums there. The odd-length case relies on the centre sample being doubled, and an off-by-one reverse alignment breaks it. Mixed signedness is tested with the top bit set on samples and coefficients: an extension of the wrong kind flips the sign or the magnitude of the product. The transfer and freeze checks look for a result register that follows the accumulator without a strobe, or a line that still moves when shifting is disabled.

// File: rtl/pfir_pkg.sv
package pfir_pkg;

    localparam int SMP_W  = 10;
    localparam int CF_W   = 10;
    localparam int LANES  = 4;
    localparam int PRE_W  = SMP_W + 2;      // signed pre-add result
    localparam int CFX_W  = CF_W + 1;       // signed coefficient
    localparam int PROD_W = PRE_W + CFX_W;

    typedef logic [SMP_W-1:0]         smp_t;
    typedef logic [CF_W-1:0]          coef_t;
    typedef logic signed [PRE_W-1:0]  pre_t;
    typedef logic signed [CFX_W-1:0]  cfx_t;
    typedef logic signed [PROD_W-1:0] prod_t;

    typedef struct packed {
        logic fwd_en;
        logic rev_en;
        logic data_sgn;
        logic coef_sgn;
    } path_sel_t;

    function automatic pre_t widen_smp(smp_t v, logic sgn);
        return PRE_W'($signed({sgn & v[SMP_W-1], v}));
    endfunction

    function automatic cfx_t widen_coef(coef_t v, logic sgn);
        return $signed({sgn & v[CF_W-1], v});
    endfunction

    function automatic int unsigned fwd_index(int unsigned d, int unsigned j);
        return j * d;
    endfunction

    // reverse tap walks back two positions per window phase
    function automatic int unsigned rev_index(int unsigned d, int unsigned j,
                                              int unsigned q, bit odd);
        return (2 * LANES - 2 - j) * d + 1 + 2 * q - (odd ? 1 : 0);
    endfunction

endpackage

// File: rtl/pfir_taps.sv
module pfir_taps import pfir_pkg::*; #(
    parameter  int DEC_MAX = 16,
    localparam int DW      = $clog2(DEC_MAX),
    localparam int DEPTH   = 2 * LANES * DEC_MAX,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift_en,
    input  smp_t                  sample_in,
    input  logic [DW-1:0]         dec_code,
    input  logic [DW-1:0]         phase,
    input  logic                  odd_len,
    output smp_t [LANES-1:0]      fwd_tap,
    output smp_t [LANES-1:0]      rev_tap
);

    smp_t        line_q [DEPTH];
    logic [DW:0] span;

    assign span = {1'b0, dec_code} + (DW+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) line_q[i] <= '0;
        end else if (shift_en) begin
            line_q[0] <= sample_in;
            for (int i = 1; i < DEPTH; i++) line_q[i] <= line_q[i-1];
        end
    end

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic [IDX_W-1:0] f_idx;
        logic [IDX_W-1:0] r_idx;
        always_comb begin
            f_idx = IDX_W'(fwd_index(32'(span), j));
            r_idx = IDX_W'(rev_index(32'(span), j, 32'(phase), odd_len));
        end
        assign fwd_tap[j] = line_q[f_idx];
        assign rev_tap[j] = line_q[r_idx];
    end

endmodule

// File: rtl/pfir_mac.sv
module pfir_mac import pfir_pkg::*; #(
    parameter int ACC_W = 28
) (
    input  smp_t  [LANES-1:0]         fwd_tap,
    input  smp_t  [LANES-1:0]         rev_tap,
    input  coef_t [LANES-1:0]         coef,
    input  path_sel_t                 sel,
    output logic signed [ACC_W-1:0]   sum
);

    prod_t prod [LANES];

    for (genvar j = 0; j < LANES; j++) begin : g_mul
        pre_t a_op, b_op, pre;
        always_comb begin
            a_op    = sel.fwd_en ? widen_smp(fwd_tap[j], sel.data_sgn) : '0;
            b_op    = sel.rev_en ? widen_smp(rev_tap[j], sel.data_sgn) : '0;
            pre     = a_op + b_op;
            prod[j] = pre * widen_coef(coef[j], sel.coef_sgn);
        end
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k < LANES; k++) sum = sum + ACC_W'(prod[k]);
    end

endmodule

// File: rtl/pfir_acc.sv
module pfir_acc #(
    parameter int ACC_W = 28,
    parameter int DW    = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    acc_en,
    input  logic                    xfer,
    input  logic [DW-1:0]           dec_code,
    input  logic signed [ACC_W-1:0] sum,
    output logic [DW-1:0]           phase_now,
    output logic [DW-1:0]           phase_q,
    output logic signed [ACC_W-1:0] acc_q,
    output logic signed [ACC_W-1:0] result_q
);

    always_comb begin
        phase_now = (acc_en && phase_q <= dec_code) ? phase_q : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= '0;
            acc_q    <= '0;
            result_q <= '0;
        end else begin
            phase_q <= (phase_now == dec_code) ? '0 : phase_now + DW'(1);
            acc_q   <= acc_en ? acc_q + sum : sum;
            if (xfer) result_q <= acc_q;
        end
    end

endmodule

// File: rtl/pfir_cell.sv
module pfir_cell import pfir_pkg::*; #(
    parameter  int DEC_MAX = 16,
    parameter  int ACC_W   = 28,
    localparam int DW      = $clog2(DEC_MAX)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [SMP_W-1:0]        sample_in,
    input  logic [LANES*CF_W-1:0]   coef_in,
    input  logic [DW-1:0]           dec_code,
    input  logic                    shift_en,
    input  logic                    fwd_en,
    input  logic                    rev_en,
    input  logic                    odd_len,
    input  logic                    acc_en,
    input  logic                    xfer,
    input  logic                    data_signed,
    input  logic                    coef_signed,
    output logic signed [ACC_W-1:0] result
);

    smp_t  [LANES-1:0]       fwd_tap, rev_tap;
    coef_t [LANES-1:0]       coefs;
    path_sel_t               sel;
    logic [DW-1:0]           phase_now, phase_q;
    logic signed [ACC_W-1:0] sum, acc_q;

    assign coefs = coef_in;
    assign sel   = '{fwd_en: fwd_en, rev_en: rev_en,
                     data_sgn: data_signed, coef_sgn: coef_signed};

    pfir_taps #(.DEC_MAX(DEC_MAX)) u_taps (
        .clk(clk), .rst(rst), .shift_en(shift_en), .sample_in(sample_in),
        .dec_code(dec_code), .phase(phase_now), .odd_len(odd_len),
        .fwd_tap(fwd_tap), .rev_tap(rev_tap)
    );

    pfir_mac #(.ACC_W(ACC_W)) u_mac (
        .fwd_tap(fwd_tap), .rev_tap(rev_tap), .coef(coefs), .sel(sel), .sum(sum)
    );

    pfir_acc #(.ACC_W(ACC_W), .DW(DW)) u_acc (
        .clk(clk), .rst(rst), .acc_en(acc_en), .xfer(xfer), .dec_code(dec_code),
        .sum(sum), .phase_now(phase_now), .phase_q(phase_q), .acc_q(acc_q),
        .result_q(result)
    );

endmodule

// File: rtl/pfir_cell_chk.sv
module pfir_cell_chk #(
    parameter int ACC_W = 28,
    parameter int DW    = 4,
    parameter int SMP_W = 10
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    shift_en,
    input logic                    fwd_en,
    input logic                    rev_en,
    input logic                    acc_en,
    input logic                    xfer,
    input logic [DW-1:0]           dec_code,
    input logic [SMP_W-1:0]        sample_in,
    input logic [SMP_W-1:0]        newest,
    input logic [DW-1:0]           phase_q,
    input logic signed [ACC_W-1:0] acc_q,
    input logic signed [ACC_W-1:0] result
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (result == '0 && acc_q == '0)); // R1

    AST_NEWEST_ENTRY: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> newest == $past(sample_in)); // R2

    AST_IDLE_LOADS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (!fwd_en && !rev_en && !acc_en) |=> acc_q == '0); // R5

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (rst)
        !acc_en |=> phase_q == (($past(dec_code) == '0) ? '0 : DW'(1))); // R7

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !xfer |=> $stable(result)); // R8

    AST_LINE_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(newest)); // R9

endmodule

bind pfir_cell pfir_cell_chk #(.ACC_W(ACC_W), .DW(DW), .SMP_W(pfir_pkg::SMP_W)) u_chk (
    .clk(clk), .rst(rst), .shift_en(shift_en), .fwd_en(fwd_en), .rev_en(rev_en),
    .acc_en(acc_en), .xfer(xfer), .dec_code(dec_code), .sample_in(sample_in),
    .newest(fwd_tap[0]), .phase_q(phase_q), .acc_q(acc_q), .result(result)
);

// File: tb/pfir_cell_test.sv
module pfir_cell_test;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [9:0]        sample_in = '0;
    logic [39:0]       coef_in = '0;
    logic [3:0]        dec_code = '0;
    logic              shift_en = 1'b0, fwd_en = 1'b0, rev_en = 1'b0;
    logic              odd_len = 1'b0, acc_en = 1'b0, xfer = 1'b0;
    logic              data_signed = 1'b1, coef_signed = 1'b1;
    logic signed [27:0] result;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #4 clk = ~clk;

    pfir_cell uut (
        .clk(clk), .rst(rst), .sample_in(sample_in), .coef_in(coef_in),
        .dec_code(dec_code), .shift_en(shift_en), .fwd_en(fwd_en), .rev_en(rev_en),
        .odd_len(odd_len), .acc_en(acc_en), .xfer(xfer), .data_signed(data_signed),
        .coef_signed(coef_signed), .result(result)
    );

    function automatic int sv(int raw, bit sgn);
        int r = raw & 1023;
        return (sgn && r >= 512) ? r - 1024 : r;
    endfunction

    function automatic logic [39:0] pack4(int a, int b, int c, int d);
        return {d[9:0], c[9:0], b[9:0], a[9:0]};
    endfunction

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // inputs change at the falling edge; outputs are read at the next falling edge
    task automatic tick(int smp, bit sh, bit fe, bit re, bit ae, bit xf, logic [39:0] cf);
        sample_in = smp[9:0];
        shift_en  = sh;
        fwd_en    = fe;
        rev_en    = re;
        acc_en    = ae;
        xfer      = xf;
        coef_in   = cf;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        for (int i = 0; i < 8; i++) tick(i * 77 + 5, 1, 0, 0, 0, 0, '0);
        tick(0, 0, 1, 1, 0, 0, pack4(3, 4, 5, 6));
        tick(0, 0, 0, 0, 0, 1, '0);
        rst = 1'b1;
        tick(0, 0, 0, 0, 0, 0, '0);
        rst = 1'b0;
        check("R1 result cleared", result, 0);
        tick(0, 0, 1, 1, 0, 0, pack4(100, 200, 300, 400));
        tick(0, 0, 0, 0, 0, 1, '0);
        check("R1 line cleared", result, 0);
    endtask

    task automatic t_even(int seed, bit ds, bit cs, string req);
        int x[1:8];
        int c[4];
        longint e;
        dec_code = 0; odd_len = 0; data_signed = ds; coef_signed = cs;
        for (int i = 1; i <= 8; i++) begin
            x[i] = (i * seed * 97 + seed * 13 + 5) % 1024;
            tick(x[i], 1, 0, 0, 0, 0, '0);
        end
        for (int k = 0; k < 4; k++) c[k] = (k * seed * 61 + 300 + seed) % 1024;
        tick(0, 0, 1, 1, 0, 0, pack4(c[0], c[1], c[2], c[3]));
        tick(0, 0, 0, 0, 0, 1, '0);
        e = longint'(sv(x[8], ds) + sv(x[1], ds)) * sv(c[0], cs)
          + longint'(sv(x[7], ds) + sv(x[2], ds)) * sv(c[1], cs)
          + longint'(sv(x[6], ds) + sv(x[3], ds)) * sv(c[2], cs)
          + longint'(sv(x[5], ds) + sv(x[4], ds)) * sv(c[3], cs);
        check(req, result, e);
    endtask

    task automatic t_odd();
        int x[1:7];
        int c[4];
        longint e;
        dec_code = 0; odd_len = 1; data_signed = 1; coef_signed = 1;
        for (int i = 1; i <= 7; i++) begin
            x[i] = (i * 211 + 40) % 1024;
            tick(x[i], 1, 0, 0, 0, 0, '0);
        end
        c[0] = 1000; c[1] = 37; c[2] = 600; c[3] = 45;
        tick(0, 0, 1, 1, 0, 0, pack4(c[0], c[1], c[2], c[3]));
        tick(0, 0, 0, 0, 0, 1, '0);
        e = longint'(sv(x[7], 1) + sv(x[1], 1)) * sv(c[0], 1)
          + longint'(sv(x[6], 1) + sv(x[2], 1)) * sv(c[1], 1)
          + longint'(sv(x[5], 1) + sv(x[3], 1)) * sv(c[2], 1)
          + longint'(2 * sv(x[4], 1)) * sv(c[3], 1);
        check("R4 odd centre doubled", result, e);
        odd_len = 0;
    endtask

    task automatic t_asym();
        int x[1:8];
        int h[8];
        longint e = 0;
        dec_code = 0; data_signed = 1; coef_signed = 1;
        for (int i = 1; i <= 8; i++) begin
            x[i] = (i * 389 + 17) % 1024;
            tick(x[i], 1, 0, 0, 0, 0, '0);
        end
        for (int m = 0; m < 8; m++) h[m] = (m * 151 + 900) % 1024;
        tick(0, 0, 1, 0, 0, 0, pack4(h[0], h[1], h[2], h[3]));
        tick(0, 0, 0, 1, 1, 0, pack4(h[7], h[6], h[5], h[4]));
        tick(0, 0, 0, 0, 0, 1, '0);
        for (int m = 0; m < 8; m++) e += longint'(h[m] >= 512 ? h[m] - 1024 : h[m]) * sv(x[8 - m], 1);
        check("R5 asymmetric two-clock (R7 accumulate)", result, e);
        tick(0, 0, 0, 0, 0, 1, '0);
        check("R5 both paths off", result, 0);
    endtask

    task automatic t_decim(int code);
        int d = code + 1;
        int h[128];
        int xs[256];
        int cnt = 0;
        longint expw[4];
        logic [39:0] cf;
        dec_code = code[3:0]; odd_len = 0; data_signed = 1; coef_signed = 1;
        for (int m = 0; m < 4 * d; m++) begin
            h[m] = ((m * 53 + code * 7 + 3) % 201) - 100;
            h[8 * d - 1 - m] = h[m];
        end
        for (int i = 0; i < 8 * d; i++) begin
            xs[cnt] = (i * 131 + code * 17 + 9) % 1024;
            tick(xs[cnt], 1, 0, 0, 0, 0, '0);
            cnt++;
        end
        for (int w = 0; w < 3; w++) begin
            for (int q = 0; q < d; q++) begin
                for (int j = 0; j < 4; j++) begin
                    int t = h[j * d + d - 1 - q];
                    cf[j * 10 +: 10] = t[9:0];
                end
                if (q == d - 1) begin
                    longint e = 0;
                    for (int m = 0; m < 8 * d; m++) e += longint'(h[m]) * sv(xs[cnt - 1 - m], 1);
                    expw[w] = e;
                end
                xs[cnt] = (cnt * 131 + code * 29 + w * 5) % 1024;
                tick(xs[cnt], 1, 1, 1, q != 0, (q == 0) && (w > 0), cf);
                cnt++;
                if (q == 0 && w > 0)
                    check($sformatf("R6 R7 decimate D=%0d window %0d", d, w - 1), result, expw[w - 1]);
            end
        end
        tick(0, 0, 0, 0, 0, 1, '0);
        check($sformatf("R6 R8 decimate D=%0d last window", d), result, expw[2]);
    endtask

    task automatic t_freeze();
        longint r1;
        dec_code = 0; odd_len = 0; data_signed = 1; coef_signed = 1;
        for (int i = 0; i < 8; i++) tick(i * 59 + 300, 1, 0, 0, 0, 0, '0);
        tick(0, 0, 1, 1, 0, 0, pack4(11, 500, 800, 77));
        tick(0, 0, 0, 0, 0, 1, '0);
        r1 = result;
        tick(999, 0, 1, 1, 0, 0, pack4(1, 2, 3, 4));
        tick(555, 0, 0, 1, 1, 0, pack4(9, 9, 9, 9));
        tick(123, 0, 1, 0, 0, 0, pack4(7, 7, 7, 7));
        check("R8 result holds without xfer", result, r1);
        tick(0, 0, 1, 1, 0, 0, pack4(11, 500, 800, 77));
        tick(0, 0, 0, 0, 0, 1, '0);
        check("R9 line frozen while shift off", result, r1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got %0d expected %0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        check("R1 result zero after reset", result, 0);
        t_reset();
        t_even(3, 1, 1, "R3 even pairs signed (R2 order)");
        t_even(7, 1, 1, "R3 even pairs second pattern");
        t_even(11, 0, 0, "R10 both unsigned");
        t_even(5, 0, 1, "R10 unsigned data signed coef");
        t_even(9, 1, 0, "R10 signed data unsigned coef");
        t_odd();
        t_asym();
        t_decim(2);
        t_decim(15);
        t_freeze();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule